// File: doc/BRIEF.md
# Programmable Bit-Destuffing Shift Unit

This unit sits behind a line receiver that has already turned the wire signal into one "changed / did not change" indication per bit time. For every enabled bit it decides whether the bit carries data or is a stuffing bit that the transmitter added after a run of ones. Data bits are shifted into an 8-bit register and counted. Stuffing bits are dropped.

The longest permitted run of ones is a run-time input. The same instance can therefore frame a serial bus that stuffs after six ones, or a link layer that stuffs after five. A limit of zero empties the run tracker, which a framer uses at the start of each packet. For every enabled bit the unit reports whether the bit was kept, when a full byte has been collected, and whether a one arrived where a stuffing zero was required. The last of these is a sticky error.

Each decision takes one clock. Results are registered and appear after the clock edge at which the enable was sampled.

Top module: `destuff_shift_unit`

## Requirements
- R1: After reset, and on the edge after `clear` is high, `shift_data`, `bit_kept`, `byte_ready`, `bit_count` and `stuff_error` are all zero. `clear` overrides `bit_en`.
- R2: The line bit is the inverse of `line_change`. `line_change`=0 means logic 1, and `line_change`=1 means logic 0. A kept bit shifts `shift_data` right by one and enters at bit 7, so the first bit of a byte ends up in bit 0.
- R3: A 1 that arrives while the run count is below `run_limit` is kept. `bit_kept` goes high and the run count increases by one.
- R4: A 0 that arrives while the run count is below `run_limit` is kept. `bit_kept` goes high and the run count returns to zero.
- R5: A 0 that arrives while the run count has reached `run_limit` is the stuffing bit and is dropped. `bit_kept` is low, `shift_data` and `bit_count` are unchanged, and the run count returns to zero.
- R6: A 1 that arrives while the run count has reached `run_limit` is dropped and leaves the run count unchanged. It also sets `stuff_error`, which stays high until `clear`.
- R7: `bit_count` advances only on kept bits. The eighth kept bit raises `byte_ready` for one cycle and brings `bit_count` back to 0 on that same edge.
- R8: An enabled bit presented with `run_limit`=0 sets the run count to zero and is not kept. Data, `bit_count` and `stuff_error` are unchanged.
- R9: While `bit_en` is low and `clear` is low, no state changes, and `bit_kept` and `byte_ready` are low.
- R10: `run_limit` may change between bits, taking any value from 1 to 15. A run count equal to or above the new limit is treated as having reached it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous clear of all state |
| bit_en | input | 1 | A line bit is presented this cycle |
| line_change | input | 1 | 1 = line changed (data 0), 0 = no change (data 1) |
| run_limit | input | 4 | Longest permitted run of ones; 0 = empty the run tracker |
| shift_data | output | 8 | Collected data, new bits enter at bit 7 |
| bit_kept | output | 1 | Last enabled bit was stored |
| byte_ready | output | 1 | One-cycle pulse when the eighth bit was stored |
| bit_count | output | 4 | Bits stored in the current byte (0..7) |
| stuff_error | output | 1 | Sticky: a 1 arrived in a stuffing position |

## Verification
Every result is due exactly one rising edge after the cycle in which `bit_en`, `line_change`, `run_limit` and `clear` were presented. This covers the data, the kept flag, the byte pulse, the count and the error. The bench drives each stimulus on a falling edge and advances a behavioural model of the stuffing rules for that bit. It then compares every output with the model on the next falling edge, half a period after the register update and before the next stimulus. Because a comparison is made on every clock, idle cycles, dropped bits and limit-zero bits are checked in the same cycle that a wrongly updated register would show them.

// File: rtl/destuff_pkg.sv
package destuff_pkg;

   // Decision taken for one presented line bit
   typedef enum logic [2:0] {
      ACT_IDLE   = 3'd0,   // no bit presented, or clear
      ACT_STORE  = 3'd1,   // data bit, goes into the shift register
      ACT_DROP   = 3'd2,   // the expected stuffing zero
      ACT_REJECT = 3'd3,   // a one where a stuffing zero was due
      ACT_RESYNC = 3'd4    // limit of zero: empty the run tracker
   } bit_action_e;

endpackage

// File: rtl/destuff_run_tracker.sv
module destuff_run_tracker
   import destuff_pkg::*;
#(
   parameter int RUN_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             bit_en,
   input  logic             one_bit,
   input  logic [RUN_W-1:0] limit,
   output bit_action_e      action,
   output logic             stuff_error
);

   logic [RUN_W-1:0] run_q;
   logic             at_limit;

   assign at_limit = (run_q >= limit);

   always_comb begin
      if (clear || !bit_en)        action = ACT_IDLE;
      else if (limit == '0)        action = ACT_RESYNC;
      else if (at_limit && one_bit) action = ACT_REJECT;
      else if (at_limit)           action = ACT_DROP;
      else                         action = ACT_STORE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q       <= '0;
         stuff_error <= 1'b0;
      end else if (clear) begin
         run_q       <= '0;
         stuff_error <= 1'b0;
      end else begin
         case (action)
            ACT_STORE:  run_q <= one_bit ? run_q + 1'b1 : '0;
            ACT_DROP,
            ACT_RESYNC: run_q <= '0;
            ACT_REJECT: stuff_error <= 1'b1;
            default:    ;
         endcase
      end
   end

   // R6
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stuff_error && !clear) |=> stuff_error);

   // R3
   one_counts_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (action == ACT_STORE && one_bit) |=> (run_q == $past(run_q) + 1'b1));

   // R5
   drop_empties_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (action == ACT_DROP) |=> (run_q == '0));

   // R6
   reject_keeps_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (action == ACT_REJECT) |=> ($stable(run_q) && stuff_error));

endmodule

// File: rtl/destuff_collector.sv
module destuff_collector #(
   parameter int DATA_W    = 8,
   parameter bit LSB_FIRST = 1'b1,
   parameter int CNT_W     = $clog2(DATA_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              store,
   input  logic              new_bit,
   output logic [DATA_W-1:0] data_q,
   output logic [CNT_W-1:0]  bit_cnt,
   output logic              byte_done,
   output logic              kept
);

   localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(DATA_W - 1);

   logic [DATA_W-1:0] shifted;

   generate
      if (LSB_FIRST) begin : g_right
         assign shifted = {new_bit, data_q[DATA_W-1:1]};
      end else begin : g_left
         assign shifted = {data_q[DATA_W-2:0], new_bit};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q    <= '0;
         bit_cnt   <= '0;
         byte_done <= 1'b0;
         kept      <= 1'b0;
      end else if (clear) begin
         data_q    <= '0;
         bit_cnt   <= '0;
         byte_done <= 1'b0;
         kept      <= 1'b0;
      end else begin
         kept      <= store;
         byte_done <= store && (bit_cnt == LAST_IDX);
         if (store) begin
            data_q  <= shifted;
            bit_cnt <= (bit_cnt == LAST_IDX) ? '0 : bit_cnt + 1'b1;
         end
      end
   end

   // R7
   done_restarts_chk: assert property (@(posedge clk) disable iff (!rst_n)
      byte_done |-> (bit_cnt == '0));

   // R9
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!store && !clear) |=> ($stable(data_q) && $stable(bit_cnt) && !kept && !byte_done));

endmodule

// File: rtl/destuff_shift_unit.sv
module destuff_shift_unit
   import destuff_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int RUN_W     = 4,
   parameter bit LSB_FIRST = 1'b1,
   parameter int CNT_W     = $clog2(DATA_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              bit_en,
   input  logic              line_change,
   input  logic [RUN_W-1:0]  run_limit,
   output logic [DATA_W-1:0] shift_data,
   output logic              bit_kept,
   output logic              byte_ready,
   output logic [CNT_W-1:0]  bit_count,
   output logic              stuff_error
);

   generate
      if (DATA_W < 2) begin : g_bad_data_w
         $error("destuff_shift_unit: DATA_W must be at least 2");
      end
      if (RUN_W < 2) begin : g_bad_run_w
         $error("destuff_shift_unit: RUN_W must be at least 2");
      end
   endgenerate

   logic        one_bit;
   bit_action_e action;

   assign one_bit = ~line_change;

   destuff_run_tracker #(.RUN_W(RUN_W)) u_run (
      .clk         (clk),
      .rst_n       (rst_n),
      .clear       (clear),
      .bit_en      (bit_en),
      .one_bit     (one_bit),
      .limit       (run_limit),
      .action      (action),
      .stuff_error (stuff_error)
   );

   destuff_collector #(
      .DATA_W    (DATA_W),
      .LSB_FIRST (LSB_FIRST),
      .CNT_W     (CNT_W)
   ) u_col (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (clear),
      .store     (action == ACT_STORE),
      .new_bit   (one_bit),
      .data_q    (shift_data),
      .bit_cnt   (bit_count),
      .byte_done (byte_ready),
      .kept      (bit_kept)
   );

   // R2
   polarity_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_en && !clear && (run_limit != '0)) |=>
         (!bit_kept || !LSB_FIRST || (shift_data[DATA_W-1] == !$past(line_change))));

   // R1
   clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (shift_data == '0 && !bit_kept && !byte_ready && bit_count == '0 && !stuff_error));

   // R8
   zero_limit_no_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_en && !clear && run_limit == '0) |=> (!bit_kept && $stable(shift_data)));

endmodule

// File: tb/destuff_shift_unit_test.sv
module destuff_shift_unit_test;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       clear = 1'b0;
   logic       bit_en = 1'b0;
   logic       line_change = 1'b0;
   logic [3:0] run_limit = 4'd6;
   logic [7:0] shift_data;
   logic       bit_kept, byte_ready, stuff_error;
   logic [3:0] bit_count;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // reference model state
   int         m_run = 0;
   int         m_cnt = 0;
   logic [7:0] m_data = 8'h00;
   logic       m_kept = 1'b0, m_done = 1'b0, m_err = 1'b0;

   logic [15:0] lf = 16'hACE1;

   always #(CLK_PERIOD/2) clk = ~clk;

   destuff_shift_unit uut (
      .clk(clk), .rst_n(rst_n), .clear(clear), .bit_en(bit_en),
      .line_change(line_change), .run_limit(run_limit),
      .shift_data(shift_data), .bit_kept(bit_kept), .byte_ready(byte_ready),
      .bit_count(bit_count), .stuff_error(stuff_error)
   );

   task automatic chk1(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic compare_all(input string tag);
      chk1(tag, "shift_data", int'(shift_data), int'(m_data));
      chk1(tag, "bit_kept", int'(bit_kept), int'(m_kept));
      chk1(tag, "byte_ready", int'(byte_ready), int'(m_done));
      chk1(tag, "bit_count", int'(bit_count), m_cnt);
      chk1(tag, "stuff_error", int'(stuff_error), int'(m_err));
   endtask

   // Advance the model by one clock following the written rules
   task automatic model_step(input logic en, input logic chg, input int lim, input logic clr);
      logic b;
      b = !chg;
      m_kept = 1'b0;
      m_done = 1'b0;
      if (clr) begin
         m_run = 0; m_cnt = 0; m_data = 8'h00; m_err = 1'b0;
      end else if (en) begin
         if (lim == 0) begin
            m_run = 0;                               // R8
         end else if (m_run >= lim) begin            // R10: at or above limit
            if (b) m_err = 1'b1;                     // R6
            else   m_run = 0;                        // R5
         end else begin
            m_data = {b, m_data[7:1]};               // R2
            m_kept = 1'b1;
            m_run  = b ? m_run + 1 : 0;              // R3 / R4
            m_cnt++;
            if (m_cnt == 8) begin                    // R7
               m_cnt  = 0;
               m_done = 1'b1;
            end
         end
      end
   endtask

   task automatic step(input logic en, input logic chg, input int lim, input logic clr, input string tag);
      bit_en      = en;
      line_change = chg;
      run_limit   = lim[3:0];
      clear       = clr;
      model_step(en, chg, lim, clr);
      @(posedge clk);
      @(negedge clk);
      compare_all(tag);
   endtask

   // send a data byte LSB first as change indications, stuffing as a transmitter would
   task automatic send_byte(input logic [7:0] v, input int lim, input string tag);
      for (int i = 0; i < 8; i++) begin
         step(1'b1, !v[i], lim, 1'b0, tag);
         if (m_run >= lim) step(1'b1, 1'b1, lim, 1'b0, "R5");
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin : stimulus
      int lim;
      repeat (3) @(negedge clk);
      compare_all("R1");                 // reset state
      rst_n = 1'b1;
      @(negedge clk);
      compare_all("R1");

      // USB-style run of six: all-ones byte needs a stuffed zero
      send_byte(8'hFF, 6, "R3");
      chk1("R7", "byte_ready after 0xFF", int'(byte_ready), 1);
      chk1("R2", "data 0xFF", int'(shift_data), 8'hFF);
      send_byte(8'hA5, 6, "R4");
      chk1("R2", "data 0xA5", int'(shift_data), 8'hA5);

      // idle cycles with a toggling line
      step(1'b0, 1'b1, 6, 1'b0, "R9");
      step(1'b0, 1'b0, 6, 1'b0, "R9");

      // HDLC-style run of five
      step(1'b1, 1'b0, 0, 1'b0, "R8");
      send_byte(8'h7F, 5, "R5");
      send_byte(8'h3E, 5, "R3");

      // one in a stuffing position: error, sticky
      step(1'b1, 1'b0, 0, 1'b0, "R8");
      for (int i = 0; i < 6; i++) step(1'b1, 1'b0, 6, 1'b0, "R3");
      step(1'b1, 1'b0, 6, 1'b0, "R6");
      chk1("R6", "error set", int'(stuff_error), 1);
      step(1'b1, 1'b1, 6, 1'b0, "R5");
      step(1'b0, 1'b0, 6, 1'b0, "R6");
      chk1("R6", "error sticky", int'(stuff_error), 1);

      // clear overrides enable
      step(1'b1, 1'b0, 6, 1'b1, "R1");
      chk1("R1", "error cleared", int'(stuff_error), 0);

      // lowering the limit below the current run
      for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 6, 1'b0, "R3");
      step(1'b1, 1'b0, 3, 1'b0, "R10");
      chk1("R10", "kept at lowered limit", int'(bit_kept), 0);
      step(1'b1, 1'b1, 3, 1'b0, "R10");
      step(1'b1, 1'b0, 3, 1'b0, "R10");
      chk1("R10", "kept after resume", int'(bit_kept), 1);

      // limit zero mid-run
      step(1'b1, 1'b0, 6, 1'b0, "R3");
      step(1'b1, 1'b0, 0, 1'b0, "R8");
      step(1'b1, 1'b1, 0, 1'b0, "R8");

      // pseudo-random stream, mostly ones so stuffing is frequent
      lim = 6;
      for (int n = 0; n < 4000; n++) begin
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         if (n % 97 == 0) lim = int'(lf[7:4]);
         step(lf[1] | lf[2], (lf[11:8] == 4'd0), lim, (n % 613 == 612), "R10");
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule